// File: doc/BRIEF.md
# Event-Driven Micro-Task Power Sequencer

This block decides, one clock at a time, which hardware micro-tasks and which shared memory get power. Event pulses from inside and outside the chip are caught in 1-bit sticky registers. Each task has a parameterized event condition built from those bits, in either all-of or any-of form. When a task's condition holds and no task that writes to the same memory or I/O resource is running or has a stronger claim, the task's 1-bit status register is set. That status register drives the task's power-gating enable directly.

When a task raises its done input, its status register clears and the event bits it used are consumed. A task whose condition holds but is blocked by a conflict keeps its events latched and is evaluated again every cycle. The shared memory has its own status register, which is on whenever at least one task that uses the memory is on. All pins are plain level control signals. There is no data stream, so there is no valid/ready handshake and no back-pressure.

Top module: `mtask_power_ctrl`

## Requirements
- R1: A synchronous reset clears every event and status register, so `task_pwr_en` is all zero and `mem_pwr_en` is low after a clock edge with `rst` high. Events presented during reset are not kept.
- R2: A one-cycle pulse on an `evt_in` bit is latched at the next edge. A task whose condition becomes true through it powers on at the edge after that, two edges after the pulse is presented.
- R3: A task in all-of mode (its `COMBINE_AND` bit is 1) powers on only once every event in its mask has been latched. The events may arrive in different cycles.
- R4: A task in any-of mode (its `COMBINE_AND` bit is 0) powers on when any one event in its mask is latched.
- R5: Two tasks marked in `MEM_CONF` (bit t*NT+m, either direction) are never powered together. A ready task waits while the other runs and powers on one edge after the other's status has cleared.
- R6: The same exclusion and retry hold for tasks marked in `IO_CONF`.
- R7: When conflicting tasks become ready in the same cycle, the lower-indexed task is powered first. The other follows after it finishes.
- R8: `task_done[t]` high while task t is powered clears `task_pwr_en[t]` at the next edge and consumes the events in its mask, so the task does not restart without new events.
- R9: `task_done[t]` while task t is unpowered has no effect. Its partly or fully latched events are kept.
- R10: `mem_pwr_en` is high exactly when at least one powered task has its `MEM_USERS` bit set. It changes on the same edge as the task enables.
- R11: If an event arrives in the same cycle as a done that consumes it, the event stays latched, so the task powers on again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Single system clock |
| rst | input | 1 | Synchronous active-high reset |
| evt_in | input | NE | Event pulses, one bit per event source |
| task_done | input | NT | Per-task completion pulse |
| task_pwr_en | output | NT | Per-task power-gating enable (status register) |
| mem_pwr_en | output | 1 | Shared memory power-gating enable |

## Verification
The hardest situation to reach is a task that is ready but kept waiting, and then retried. This needs two conflicting tasks with latched events, one of them already powered, and the done of the running task landing in a specific cycle. The stimulus starts the higher-index task first and only then pulses the lower-index task's event. It releases the running task one cycle at a time, which shows that the waiting task powers on exactly one edge after the release. It also shows that the events of the waiting task survived the whole blocked interval. Simultaneous readiness, done on an idle task, and an event colliding with its own consumption are each set up the same way, by placing pulses in chosen cycles.

// File: rtl/mtp_pkg.sv
package mtp_pkg;
  typedef enum logic {
    CMB_ANY = 1'b0,
    CMB_ALL = 1'b1
  } combine_e;
endpackage

// File: rtl/mtp_event_bank.sv
module mtp_event_bank #(
  parameter int unsigned NE = 6
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [NE-1:0] evt_in,
  input  logic [NE-1:0] consume,
  output logic [NE-1:0] evt_q
);
  // Arrival has priority over consumption in the same cycle.
  always_ff @(posedge clk) begin
    if (rst) evt_q <= '0;
    else     evt_q <= (evt_q & ~consume) | evt_in;
  end
endmodule

// File: rtl/mtp_guard.sv
module mtp_guard
  import mtp_pkg::*;
#(
  parameter int unsigned          NT          = 4,
  parameter int unsigned          NE          = 6,
  parameter logic [NT*NE-1:0]     EVT_MASK    = '0,
  parameter logic [NT-1:0]        COMBINE_AND = '0,
  parameter logic [NT*NT-1:0]     MEM_CONF    = '0,
  parameter logic [NT*NT-1:0]     IO_CONF     = '0
) (
  input  logic [NE-1:0] evt_q,
  input  logic [NT-1:0] stat_q,
  output logic [NT-1:0] cfg_true,
  output logic [NT-1:0] grant
);
  function automatic logic [NT*NT-1:0] merge_sym(input logic [NT*NT-1:0] a,
                                                 input logic [NT*NT-1:0] b);
    logic [NT*NT-1:0] r;
    r = '0;
    for (int i = 0; i < int'(NT); i++)
      for (int j = 0; j < int'(NT); j++)
        if (i != j)
          r[i*NT+j] = a[i*NT+j] | a[j*NT+i] | b[i*NT+j] | b[j*NT+i];
    return r;
  endfunction

  localparam logic [NT*NT-1:0] CONF_ALL = merge_sym(MEM_CONF, IO_CONF);

  for (genvar t = 0; t < NT; t++) begin : g_cfg
    localparam logic [NE-1:0] MASK = EVT_MASK[t*NE +: NE];
    localparam combine_e      MODE = combine_e'(COMBINE_AND[t]);
    if (MODE == CMB_ALL) begin : g_all
      assign cfg_true[t] = (MASK != '0) && ((evt_q & MASK) == MASK);
    end else begin : g_any
      assign cfg_true[t] = |(evt_q & MASK);
    end
  end

  // A task is granted when its condition holds, it is idle, no conflicting
  // task is powered, and no lower-indexed conflicting task is also ready.
  always_comb begin
    grant = '0;
    for (int t = 0; t < int'(NT); t++) begin
      logic blocked;
      blocked = 1'b0;
      for (int m = 0; m < int'(NT); m++) begin
        if (m != t && CONF_ALL[t*NT+m]) begin
          if (stat_q[m]) blocked = 1'b1;
          if (m < t && cfg_true[m]) blocked = 1'b1;
        end
      end
      grant[t] = cfg_true[t] & ~stat_q[t] & ~blocked;
    end
  end
endmodule

// File: rtl/mtp_status_bank.sv
module mtp_status_bank #(
  parameter int unsigned      NT        = 4,
  parameter int unsigned      NE        = 6,
  parameter logic [NT*NE-1:0] EVT_MASK  = '0,
  parameter logic [NT-1:0]    MEM_USERS = '0
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [NT-1:0] grant,
  input  logic [NT-1:0] done,
  output logic [NT-1:0] stat_q,
  output logic          mem_q,
  output logic [NE-1:0] consume
);
  logic [NT-1:0] stat_d;
  logic [NT-1:0] finish;

  assign finish = done & stat_q;
  assign stat_d = (stat_q & ~finish) | grant;

  always_comb begin
    consume = '0;
    for (int t = 0; t < int'(NT); t++)
      if (finish[t]) consume = consume | EVT_MASK[t*NE +: NE];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      stat_q <= '0;
      mem_q  <= 1'b0;
    end else begin
      stat_q <= stat_d;
      mem_q  <= |(stat_d & MEM_USERS);
    end
  end
endmodule

// File: rtl/mtask_power_ctrl.sv
module mtask_power_ctrl #(
  parameter int unsigned      NT          = 4,
  parameter int unsigned      NE          = 6,
  parameter logic [NT*NE-1:0] EVT_MASK    = 24'b110000_001000_000110_000001,
  parameter logic [NT-1:0]    COMBINE_AND = 4'b0010,
  parameter logic [NT*NT-1:0] MEM_CONF    = 16'h0012,
  parameter logic [NT*NT-1:0] IO_CONF     = 16'h4800,
  parameter logic [NT-1:0]    MEM_USERS   = 4'b0111
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [NE-1:0] evt_in,
  input  logic [NT-1:0] task_done,
  output logic [NT-1:0] task_pwr_en,
  output logic          mem_pwr_en
);
  logic [NE-1:0] evt_q;
  logic [NE-1:0] consume;
  logic [NT-1:0] cfg_true;
  logic [NT-1:0] grant;
  logic [NT-1:0] stat_q;
  logic          mem_q;

  mtp_event_bank #(.NE(NE)) evt_i (
    .clk(clk), .rst(rst), .evt_in(evt_in), .consume(consume), .evt_q(evt_q)
  );

  mtp_guard #(
    .NT(NT), .NE(NE), .EVT_MASK(EVT_MASK), .COMBINE_AND(COMBINE_AND),
    .MEM_CONF(MEM_CONF), .IO_CONF(IO_CONF)
  ) guard_i (
    .evt_q(evt_q), .stat_q(stat_q), .cfg_true(cfg_true), .grant(grant)
  );

  mtp_status_bank #(
    .NT(NT), .NE(NE), .EVT_MASK(EVT_MASK), .MEM_USERS(MEM_USERS)
  ) stat_i (
    .clk(clk), .rst(rst), .grant(grant), .done(task_done),
    .stat_q(stat_q), .mem_q(mem_q), .consume(consume)
  );

  assign task_pwr_en = stat_q;
  assign mem_pwr_en  = mem_q;
endmodule

// File: rtl/mtask_power_ctrl_chk.sv
module mtask_power_ctrl_chk #(
  parameter int unsigned      NT        = 4,
  parameter logic [NT*NT-1:0] MEM_CONF  = '0,
  parameter logic [NT*NT-1:0] IO_CONF   = '0,
  parameter logic [NT-1:0]    MEM_USERS = '0
) (
  input logic          clk,
  input logic          rst,
  input logic [NT-1:0] task_done,
  input logic [NT-1:0] task_pwr_en,
  input logic          mem_pwr_en
);
  // R1
  reset_off_chk: assert property (@(posedge clk)
    rst |=> (task_pwr_en == '0 && !mem_pwr_en));

  // R10
  mem_follow_chk: assert property (@(posedge clk) disable iff (rst)
    mem_pwr_en == |(task_pwr_en & MEM_USERS));

  for (genvar t = 0; t < NT; t++) begin : g_task
    // R8
    done_off_chk: assert property (@(posedge clk) disable iff (rst)
      (task_done[t] && task_pwr_en[t]) |=> !task_pwr_en[t]);

    for (genvar m = t + 1; m < NT; m++) begin : g_pair
      if (MEM_CONF[t*NT+m] || MEM_CONF[m*NT+t]) begin : g_mem
        // R5
        mem_excl_chk: assert property (@(posedge clk) disable iff (rst)
          !(task_pwr_en[t] && task_pwr_en[m]));
      end
      if (IO_CONF[t*NT+m] || IO_CONF[m*NT+t]) begin : g_io
        // R6
        io_excl_chk: assert property (@(posedge clk) disable iff (rst)
          !(task_pwr_en[t] && task_pwr_en[m]));
      end
    end
  end
endmodule

bind mtask_power_ctrl mtask_power_ctrl_chk #(
  .NT(NT), .MEM_CONF(MEM_CONF), .IO_CONF(IO_CONF), .MEM_USERS(MEM_USERS)
) chk_i (
  .clk(clk), .rst(rst), .task_done(task_done),
  .task_pwr_en(task_pwr_en), .mem_pwr_en(mem_pwr_en)
);

// File: tb/mtask_power_ctrl_tb_top.sv
module mtask_power_ctrl_tb_top;
  // Default configuration of the DUT:
  // T0 any-of {e0}; T1 all-of {e1,e2}; T2 any-of {e3}; T3 any-of {e4,e5}
  // T0/T1 share memory writes; T2/T3 share I/O writes; T0..T2 use memory.
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [5:0] evt_in = '0;
  logic [3:0] task_done = '0;
  logic [3:0] task_pwr_en;
  logic       mem_pwr_en;

  int checks = 0;
  int failures = 0;
  bit finished = 1'b0;

  typedef struct {
    logic [3:0] pwr;
    logic       mem;
    string      tag;
  } exp_t;

  exp_t exp_q[$];

  always #10 clk = ~clk;

  mtask_power_ctrl dut_i (
    .clk(clk), .rst(rst), .evt_in(evt_in), .task_done(task_done),
    .task_pwr_en(task_pwr_en), .mem_pwr_en(mem_pwr_en)
  );

  // Driver: sets inputs for one cycle and queues the outputs expected after that edge.
  task automatic step(input logic [5:0] ev, input logic [3:0] dn,
                      input logic [3:0] ep, input string tag);
    exp_t e;
    @(negedge clk);
    rst = 1'b0;
    evt_in = ev;
    task_done = dn;
    e.pwr = ep;
    e.mem = |(ep & 4'b0111);
    e.tag = tag;
    exp_q.push_back(e);
  endtask

  // Monitor: compares outputs just after each edge against the queue.
  initial begin
    forever begin
      @(posedge clk);
      #2;
      if (exp_q.size() != 0) begin
        exp_t e;
        e = exp_q.pop_front();
        checks++;
        if (task_pwr_en !== e.pwr || mem_pwr_en !== e.mem) begin
          failures++;
          $display("FAIL %s: pwr=%b mem=%b expected pwr=%b mem=%b",
                   e.tag, task_pwr_en, mem_pwr_en, e.pwr, e.mem);
        end
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      failures++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    exp_t e;
    // R1: events offered during reset must not be kept
    evt_in = 6'h3F;
    repeat (2) @(negedge clk);
    e.pwr = 4'b0000; e.mem = 1'b0; e.tag = "R1 in reset";
    exp_q.push_back(e);
    step(6'b000000, 4'b0000, 4'b0000, "R1 after release");
    step(6'b000000, 4'b0000, 4'b0000, "R1 no stale events");

    // R2 / R4: any-of pulse on e0 powers T0 two edges later
    step(6'b000001, 4'b0000, 4'b0000, "R2 latch edge");
    step(6'b000000, 4'b0000, 4'b0001, "R2 power on");
    step(6'b000000, 4'b0000, 4'b0001, "R10 hold");
    // R8: done clears and consumes
    step(6'b000000, 4'b0001, 4'b0000, "R8 done off");
    step(6'b000000, 4'b0000, 4'b0000, "R8 no restart");

    // R3: all-of across cycles
    step(6'b000010, 4'b0000, 4'b0000, "R3 first event");
    step(6'b000000, 4'b0000, 4'b0000, "R3 partial");
    step(6'b000100, 4'b0000, 4'b0000, "R3 second event");
    step(6'b000000, 4'b0000, 4'b0010, "R3 all present");
    step(6'b000000, 4'b0010, 4'b0000, "R8 T1 done");

    // R5: T1 running blocks lower-index T0, T0 retries after release
    step(6'b000110, 4'b0000, 4'b0000, "R5 latch T1");
    step(6'b000000, 4'b0000, 4'b0010, "R5 T1 on");
    step(6'b000001, 4'b0000, 4'b0010, "R5 latch T0");
    step(6'b000000, 4'b0000, 4'b0010, "R5 T0 blocked");
    step(6'b000000, 4'b0000, 4'b0010, "R5 T0 still blocked");
    step(6'b000000, 4'b0010, 4'b0000, "R5 release edge");
    step(6'b000000, 4'b0000, 4'b0001, "R5 T0 retried");
    step(6'b000000, 4'b0001, 4'b0000, "R5 T0 done");

    // R7: simultaneous readiness, lower index first
    step(6'b000111, 4'b0000, 4'b0000, "R7 latch both");
    step(6'b000000, 4'b0000, 4'b0001, "R7 T0 wins");
    step(6'b000000, 4'b0001, 4'b0000, "R7 T0 done");
    step(6'b000000, 4'b0000, 4'b0010, "R7 T1 follows");
    step(6'b000000, 4'b0010, 4'b0000, "R7 T1 done");

    // R6 / R10: I/O conflict between T2 and T3; T3 does not use memory
    step(6'b011000, 4'b0000, 4'b0000, "R6 latch both");
    step(6'b000000, 4'b0000, 4'b0100, "R6 T2 first");
    step(6'b000000, 4'b0100, 4'b0000, "R6 T2 done");
    step(6'b000000, 4'b0000, 4'b1000, "R10 T3 without memory");
    step(6'b000000, 4'b1000, 4'b0000, "R6 T3 done");

    // R4: T3 from its other event alone; unrelated tasks run together
    step(6'b100001, 4'b0000, 4'b0000, "R4 latch");
    step(6'b000000, 4'b0000, 4'b1001, "R4 T3 and T0 together");
    step(6'b000000, 4'b1001, 4'b0000, "R8 both done");

    // R9: done on an idle task is ignored
    step(6'b000001, 4'b0001, 4'b0000, "R9 done while idle");
    step(6'b000000, 4'b0000, 4'b0001, "R9 event kept");
    step(6'b000000, 4'b0001, 4'b0000, "R9 T0 done");
    step(6'b000010, 4'b0000, 4'b0000, "R9 partial T1");
    step(6'b000000, 4'b0010, 4'b0000, "R9 idle done T1");
    step(6'b000100, 4'b0000, 4'b0000, "R9 rest of T1");
    step(6'b000000, 4'b0000, 4'b0010, "R9 partial event kept");
    step(6'b000000, 4'b0010, 4'b0000, "R9 T1 done");

    // R11: event arriving with its own consumption stays latched
    step(6'b000001, 4'b0000, 4'b0000, "R11 latch");
    step(6'b000000, 4'b0000, 4'b0001, "R11 T0 on");
    step(6'b000001, 4'b0001, 4'b0000, "R11 done with new event");
    step(6'b000000, 4'b0000, 4'b0001, "R11 T0 again");
    step(6'b000000, 4'b0001, 4'b0000, "R11 T0 done");
    step(6'b000000, 4'b0000, 4'b0000, "R8 all idle");

    @(posedge clk);
    #5;
    finished = 1'b1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule